// File: doc/BRIEF.md
# Hashed Indirect Branch Target Cache

This block predicts where an indirect branch will go. It keeps a set-associative table of branch tags and targets. The set is selected by a hash that mixes the aligned branch address, a global direction-history value and a short list of recently taken targets. The history value and the target list are kept elsewhere in the front end and arrive here as inputs. The lookup side is purely combinational, so a fetch stage can read a hit flag and a predicted target in the same cycle that it presents the branch address.

When a branch resolves, the back end presents the same hash inputs the prediction used, together with the resolved target. The table is written at the next clock edge. If the branch is already present in the selected set, only its stored target is replaced. If it is not present, one way of that set is chosen pseudo-randomly by a free-running shift register, and the new tag and target are written into it.

Top module: `itgt_cache`

## Requirements
- R1: After reset every way is invalid, so every lookup reports a miss until an update has been written.
- R2: SETS is a power of two. The set index is the XOR of all enabled hash terms, keeping the low log2(SETS) bits. The base term is the branch address shifted right by ALIGN.
- R3: With USE_HIST set, the history input is zero-extended and XORed into the index. With USE_HIST clear, the history input has no effect on any lookup.
- R4: With USE_PATH set, path entry p (entry 0 is the youngest) is shifted right by ALIGN + p*STEP and XORed into the index, where STEP = log2(SETS)/PATH_LEN rounded down. Only entries with p < count take part, and a count above PATH_LEN uses all entries. With USE_PATH clear, the path inputs have no effect.
- R5: The tag is the low TAG_W bits of the address after the shift by ALIGN. Address bits below ALIGN never affect a lookup. Bits at ALIGN+TAG_W and above do not affect the tag.
- R6: A lookup reports a hit only when a valid way of the indexed set holds the same tag. On a hit it returns that way's stored target.
- R7: An update whose tag is already valid in the indexed set rewrites only that way's target. It allocates nothing and leaves every other way unchanged.
- R8: An update with no tag match writes valid, tag and target into exactly one way of the indexed set, picked by a free-running LFSR reduced modulo WAYS. Other sets are untouched, so a set holds at most WAYS distinct branches.
- R9: An update takes effect at the clock edge where it is sampled. A lookup in that same cycle still sees the old contents. From the next cycle on, a lookup with the same inputs hits and returns the new target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | ADDR_W | Branch address for lookup |
| lk_hist | input | HIST_W | Global history value for lookup |
| lk_path | input | PATH_LEN*ADDR_W | Recent targets for lookup, entry 0 youngest |
| lk_cnt | input | CNT_W | Number of valid path entries for lookup |
| lk_hit | output | 1 | Lookup found a matching valid way |
| lk_tgt | output | ADDR_W | Predicted target, zero on a miss |
| up_en | input | 1 | Update strobe |
| up_pc | input | ADDR_W | Resolved branch address |
| up_hist | input | HIST_W | History snapshot taken at prediction |
| up_path | input | PATH_LEN*ADDR_W | Path targets taken at prediction |
| up_cnt | input | CNT_W | Number of valid path entries for update |
| up_tgt | input | ADDR_W | Resolved target to store |

## Verification
A wrong hash term shows up in the very next lookup after an update. The lookup lands in a different set and misses where a hit is expected, or it hits where the history or path inputs should have moved it to another set. A corrupted valid bit or tag shows up either as a hit right after reset or as a second branch vanishing from its set after a refresh that should not have allocated. Since reads are combinational, any bad table state appears on the port within one cycle of the write that caused it. The random choice of way is never predicted. Only its visible limits are checked: one way per allocation, and the set never holding more than WAYS entries.

// File: rtl/itgt_pkg.sv
package itgt_pkg;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    typedef enum logic [1:0] {
        UPD_IDLE    = 2'd0,
        UPD_REFRESH = 2'd1,
        UPD_ALLOC   = 2'd2
    } upd_kind_e;

    // One Galois step, shifting toward bit 0
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction

endpackage

// File: rtl/itgt_hash.sv
module itgt_hash #(
    parameter int ADDR_W   = 16,
    parameter int HIST_W   = 4,
    parameter int SETS     = 8,
    parameter int TAG_W    = 6,
    parameter int PATH_LEN = 2,
    parameter int ALIGN    = 2,
    parameter int USE_HIST = 1,
    parameter int USE_PATH = 1,
    localparam int IDX_W   = $clog2(SETS),
    localparam int CNT_W   = $clog2(PATH_LEN + 1),
    localparam int STEP    = IDX_W / PATH_LEN
) (
    input  logic [ADDR_W-1:0]                pc,
    input  logic [HIST_W-1:0]                hist,
    input  logic [PATH_LEN-1:0][ADDR_W-1:0]  path,
    input  logic [CNT_W-1:0]                 cnt,
    output logic [IDX_W-1:0]                 idx,
    output logic [TAG_W-1:0]                 tag
);

    if ((SETS & (SETS - 1)) != 0) begin : g_bad_sets
        $error("SETS must be a power of two");
    end

    logic [IDX_W+HIST_W-1:0] hist_ext;
    logic [IDX_W-1:0]        path_term [PATH_LEN];
    logic [IDX_W-1:0]        acc;

    assign hist_ext = {{IDX_W{1'b0}}, hist};

    for (genvar p = 0; p < PATH_LEN; p++) begin : g_path
        localparam int SH = ALIGN + p * STEP;
        logic [ADDR_W-1:0] shifted;
        assign shifted = path[p] >> SH;
        if (USE_PATH != 0) begin : g_on
            assign path_term[p] = (p < int'(cnt)) ? shifted[IDX_W-1:0] : '0;
        end else begin : g_off
            assign path_term[p] = '0;
        end
    end

    always_comb begin
        acc = pc[ALIGN +: IDX_W];
        if (USE_HIST != 0) begin
            acc = acc ^ hist_ext[IDX_W-1:0];
        end
        for (int p = 0; p < PATH_LEN; p++) begin
            acc = acc ^ path_term[p];
        end
    end

    assign idx = acc;
    assign tag = pc[ALIGN +: TAG_W];

endmodule

// File: rtl/itgt_lfsr.sv
module itgt_lfsr
    import itgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LFSR_SEED;
        end else begin
            state_q <= lfsr_step(state_q);
        end
    end

    assign state = state_q;

endmodule

// File: rtl/itgt_store.sv
module itgt_store
    import itgt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 8,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 6,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int ENTS  = SETS * WAYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_tgt,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  logic [WAY_W-1:0]  victim,
    output logic [ENTS-1:0]   vld_flat,
    output logic [WAYS-1:0]   way_we
);

    logic              vld_q [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q [SETS][WAYS];
    logic [ADDR_W-1:0] tgt_q [SETS][WAYS];

    logic [WAYS-1:0]   wr_match;
    logic [WAY_W-1:0]  match_way;
    upd_kind_e         kind;

    // Read port: lowest matching way wins
    always_comb begin
        rd_hit = 1'b0;
        rd_tgt = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vld_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag)) begin
                rd_hit = 1'b1;
                rd_tgt = tgt_q[rd_idx][w];
            end
        end
    end

    // Write side: classify the update
    always_comb begin
        match_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            wr_match[w] = vld_q[wr_idx][w] && (tag_q[wr_idx][w] == wr_tag);
            if (wr_match[w]) begin
                match_way = WAY_W'(w);
            end
        end
        if (!wr_en) begin
            kind = UPD_IDLE;
        end else if (|wr_match) begin
            kind = UPD_REFRESH;
        end else begin
            kind = UPD_ALLOC;
        end
    end

    always_comb begin
        way_we = '0;
        for (int w = 0; w < WAYS; w++) begin
            case (kind)
                UPD_REFRESH: way_we[w] = (match_way == WAY_W'(w));
                UPD_ALLOC:   way_we[w] = (victim == WAY_W'(w));
                default:     way_we[w] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    vld_q[s][w] <= 1'b0;
                end
            end
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (way_we[w] && kind == UPD_ALLOC) begin
                    vld_q[wr_idx][w] <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < WAYS; w++) begin
            if (way_we[w]) begin
                tgt_q[wr_idx][w] <= wr_tgt;
                if (kind == UPD_ALLOC) begin
                    tag_q[wr_idx][w] <= wr_tag;
                end
            end
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_vs
        for (genvar w = 0; w < WAYS; w++) begin : g_vw
            assign vld_flat[s * WAYS + w] = vld_q[s][w];
        end
    end

endmodule

// File: rtl/itgt_cache.sv
module itgt_cache
    import itgt_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int HIST_W   = 4,
    parameter int SETS     = 8,
    parameter int WAYS     = 2,
    parameter int TAG_W    = 6,
    parameter int PATH_LEN = 2,
    parameter int ALIGN    = 2,
    parameter int USE_HIST = 1,
    parameter int USE_PATH = 1,
    localparam int IDX_W   = $clog2(SETS),
    localparam int CNT_W   = $clog2(PATH_LEN + 1),
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int ENTS    = SETS * WAYS
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [ADDR_W-1:0]                lk_pc,
    input  logic [HIST_W-1:0]                lk_hist,
    input  logic [PATH_LEN-1:0][ADDR_W-1:0]  lk_path,
    input  logic [CNT_W-1:0]                 lk_cnt,
    output logic                             lk_hit,
    output logic [ADDR_W-1:0]                lk_tgt,
    input  logic                             up_en,
    input  logic [ADDR_W-1:0]                up_pc,
    input  logic [HIST_W-1:0]                up_hist,
    input  logic [PATH_LEN-1:0][ADDR_W-1:0]  up_path,
    input  logic [CNT_W-1:0]                 up_cnt,
    input  logic [ADDR_W-1:0]                up_tgt
);

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic [LFSR_W-1:0] rnd;
    logic [WAY_W-1:0]  victim;
    logic [ENTS-1:0]   vld_flat;
    logic [WAYS-1:0]   way_we;

    itgt_hash #(
        .ADDR_W(ADDR_W), .HIST_W(HIST_W), .SETS(SETS), .TAG_W(TAG_W),
        .PATH_LEN(PATH_LEN), .ALIGN(ALIGN), .USE_HIST(USE_HIST), .USE_PATH(USE_PATH)
    ) u_hash_lk (
        .pc(lk_pc), .hist(lk_hist), .path(lk_path), .cnt(lk_cnt),
        .idx(lk_idx), .tag(lk_tag)
    );

    itgt_hash #(
        .ADDR_W(ADDR_W), .HIST_W(HIST_W), .SETS(SETS), .TAG_W(TAG_W),
        .PATH_LEN(PATH_LEN), .ALIGN(ALIGN), .USE_HIST(USE_HIST), .USE_PATH(USE_PATH)
    ) u_hash_up (
        .pc(up_pc), .hist(up_hist), .path(up_path), .cnt(up_cnt),
        .idx(up_idx), .tag(up_tag)
    );

    itgt_lfsr u_lfsr (
        .clk(clk), .rst(rst), .state(rnd)
    );

    assign victim = WAY_W'(rnd % LFSR_W'(WAYS));

    itgt_store #(
        .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_hit(lk_hit), .rd_tgt(lk_tgt),
        .wr_en(up_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(up_tgt),
        .victim(victim), .vld_flat(vld_flat), .way_we(way_we)
    );

endmodule

// File: rtl/itgt_chk.sv
module itgt_chk #(
    parameter int ADDR_W   = 16,
    parameter int HIST_W   = 4,
    parameter int PATH_LEN = 2,
    parameter int CNT_W    = 2,
    parameter int WAYS     = 2,
    parameter int ENTS     = 16
) (
    input logic                             clk,
    input logic                             rst,
    input logic [ADDR_W-1:0]                lk_pc,
    input logic [HIST_W-1:0]                lk_hist,
    input logic [PATH_LEN-1:0][ADDR_W-1:0]  lk_path,
    input logic [CNT_W-1:0]                 lk_cnt,
    input logic                             lk_hit,
    input logic [ADDR_W-1:0]                lk_tgt,
    input logic                             up_en,
    input logic [ADDR_W-1:0]                up_pc,
    input logic [HIST_W-1:0]                up_hist,
    input logic [PATH_LEN-1:0][ADDR_W-1:0]  up_path,
    input logic [CNT_W-1:0]                 up_cnt,
    input logic [ADDR_W-1:0]                up_tgt,
    input logic [ENTS-1:0]                  vld_flat,
    input logic [WAYS-1:0]                  way_we
);

    // R1: nothing hits in the first cycle after reset
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    // R9: a lookup matching the previous cycle's update returns its target
    a_r9_write_visible: assert property (@(posedge clk) disable iff (rst)
        up_en |=> ((lk_pc != $past(up_pc)) || (lk_hist != $past(up_hist)) ||
                   (lk_path != $past(up_path)) || (lk_cnt != $past(up_cnt)) ||
                   (lk_hit && lk_tgt == $past(up_tgt))));

    // R8: at most one way is written per update
    a_r8_single_way: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_we));

    // R8: an allocation adds at most one valid entry
    a_r8_one_new_valid: assert property (@(posedge clk) disable iff (rst)
        up_en |=> ($countones(vld_flat) <= $countones($past(vld_flat)) + 1));

    // R7: without an update the valid state holds
    a_r7_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        !up_en |=> $stable(vld_flat));

    // R6: a hit needs at least one valid way
    a_r6_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (|vld_flat));

endmodule

bind itgt_cache itgt_chk #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .PATH_LEN(PATH_LEN),
    .CNT_W(CNT_W), .WAYS(WAYS), .ENTS(ENTS)
) u_chk (
    .clk(clk), .rst(rst),
    .lk_pc(lk_pc), .lk_hist(lk_hist), .lk_path(lk_path), .lk_cnt(lk_cnt),
    .lk_hit(lk_hit), .lk_tgt(lk_tgt),
    .up_en(up_en), .up_pc(up_pc), .up_hist(up_hist), .up_path(up_path),
    .up_cnt(up_cnt), .up_tgt(up_tgt),
    .vld_flat(vld_flat), .way_we(way_we)
);

// File: tb/sim_itgt_cache.sv
module sim_itgt_cache;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [AW-1:0]     lk_pc = '0;
    logic [3:0]        lk_hist = '0;
    logic [1:0][AW-1:0] lk_path = '0;
    logic [1:0]        lk_cnt = '0;
    logic              up_en = 1'b0;
    logic [AW-1:0]     up_pc = '0;
    logic [3:0]        up_hist = '0;
    logic [1:0][AW-1:0] up_path = '0;
    logic [1:0]        up_cnt = '0;
    logic [AW-1:0]     up_tgt = '0;

    logic              hit0, hit1;
    logic [AW-1:0]     tgt0, tgt1;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    itgt_cache #(.ADDR_W(AW), .HIST_W(4), .SETS(8), .WAYS(2), .TAG_W(6),
                 .PATH_LEN(2), .ALIGN(2), .USE_HIST(1), .USE_PATH(1)) u0 (
        .clk(clk), .rst(rst),
        .lk_pc(lk_pc), .lk_hist(lk_hist), .lk_path(lk_path), .lk_cnt(lk_cnt),
        .lk_hit(hit0), .lk_tgt(tgt0),
        .up_en(up_en), .up_pc(up_pc), .up_hist(up_hist), .up_path(up_path),
        .up_cnt(up_cnt), .up_tgt(up_tgt)
    );

    itgt_cache #(.ADDR_W(AW), .HIST_W(4), .SETS(8), .WAYS(2), .TAG_W(6),
                 .PATH_LEN(2), .ALIGN(2), .USE_HIST(0), .USE_PATH(0)) u1 (
        .clk(clk), .rst(rst),
        .lk_pc(lk_pc), .lk_hist(lk_hist), .lk_path(lk_path), .lk_cnt(lk_cnt),
        .lk_hit(hit1), .lk_tgt(tgt1),
        .up_en(up_en), .up_pc(up_pc), .up_hist(up_hist), .up_path(up_path),
        .up_cnt(up_cnt), .up_tgt(up_tgt)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare a lookup result; on a miss only the hit flag is compared
    task automatic expect_lk(input string req, input logic hit, input logic [AW-1:0] tgt,
                             input logic exp_hit, input logic [AW-1:0] exp_tgt);
        if (exp_hit) chk(hit && tgt == exp_tgt, req, {15'd0, hit, tgt}, {15'd0, 1'b1, exp_tgt});
        else         chk(!hit, req, {31'd0, hit}, 32'd0);
    endtask

    task automatic look(input logic [AW-1:0] pc, input logic [3:0] h,
                        input logic [AW-1:0] t0, input logic [AW-1:0] t1,
                        input logic [1:0] c);
        @(negedge clk);
        lk_pc = pc; lk_hist = h; lk_path[0] = t0; lk_path[1] = t1; lk_cnt = c;
        #1;
    endtask

    task automatic upd(input logic [AW-1:0] pc, input logic [3:0] h,
                       input logic [AW-1:0] tgt);
        @(negedge clk);
        up_en = 1'b1; up_pc = pc; up_hist = h; up_path = '0; up_cnt = 2'd0; up_tgt = tgt;
        @(negedge clk);
        up_en = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    localparam logic [AW-1:0] P  = 16'h0124; // aligned 0x49: set 1, tag 0x09
    localparam logic [AW-1:0] P2 = 16'h0104; // aligned 0x41: set 1, tag 0x01

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R1: empty table after reset, both hash variants
        for (int i = 0; i < 64; i++) begin
            look(AW'(i << 2), 4'd0, '0, '0, 2'd0);
            expect_lk("R1 reset miss u0", hit0, tgt0, 1'b0, '0);
            expect_lk("R1 reset miss u1", hit1, tgt1, 1'b0, '0);
        end

        // R9: same-cycle lookup sees old contents, next cycle sees new
        @(negedge clk);
        up_en = 1'b1; up_pc = P; up_hist = '0; up_path = '0; up_cnt = '0; up_tgt = 16'hBEEF;
        lk_pc = P; lk_hist = '0; lk_path = '0; lk_cnt = '0;
        #1;
        expect_lk("R9 old contents in write cycle", hit0, tgt0, 1'b0, '0);
        @(negedge clk);
        up_en = 1'b0;
        #1;
        expect_lk("R9 R6 hit after write", hit0, tgt0, 1'b1, 16'hBEEF);
        expect_lk("R6 hit after write u1", hit1, tgt1, 1'b1, 16'hBEEF);

        // R3 R2: history folds into index with mask SETS-1
        for (int h = 0; h < 16; h++) begin
            look(P, 4'(h), '0, '0, 2'd0);
            expect_lk("R3 R2 history hash", hit0, tgt0, (h & 7) == 0, 16'hBEEF);
            expect_lk("R3 history ignored when off", hit1, tgt1, 1'b1, 16'hBEEF);
        end

        // R4: youngest target shifted by ALIGN, older entry ignored at count 1
        for (int x = 0; x < 64; x++) begin
            look(P, 4'd0, AW'(x), 16'h00F8, 2'd1);
            expect_lk("R4 path entry 0", hit0, tgt0, ((x >> 2) & 7) == 0, 16'hBEEF);
            expect_lk("R4 path ignored when off", hit1, tgt1, 1'b1, 16'hBEEF);
        end
        // R4: older target shifted by ALIGN + STEP = 3
        for (int y = 0; y < 64; y++) begin
            look(P, 4'd0, '0, AW'(y), 2'd2);
            expect_lk("R4 path entry 1", hit0, tgt0, ((y >> 3) & 7) == 0, 16'hBEEF);
        end
        look(P, 4'd0, '0, 16'h0008, 2'd3);
        expect_lk("R4 count above length uses all", hit0, tgt0, 1'b0, '0);
        look(P, 4'd0, '0, 16'h0008, 2'd0);
        expect_lk("R4 count zero ignores path", hit0, tgt0, 1'b1, 16'hBEEF);

        // R5: tag extraction
        look(P ^ 16'h0003, 4'd0, '0, '0, 2'd0);
        expect_lk("R5 low bits ignored", hit0, tgt0, 1'b1, 16'hBEEF);
        look(P ^ 16'h0020, 4'd0, '0, '0, 2'd0);
        expect_lk("R5 R6 tag bit differs", hit0, tgt0, 1'b0, '0);
        look(P ^ 16'h0100, 4'd0, '0, '0, 2'd0);
        expect_lk("R5 bit above tag ignored", hit0, tgt0, 1'b1, 16'hBEEF);
        look(P ^ 16'h0004, 4'd1, '0, '0, 2'd0);
        expect_lk("R6 same set other tag", hit0, tgt0, 1'b0, '0);

        // R7: refresh keeps the other way intact
        do_reset();
        upd(P, 4'd0, 16'hAAAA);
        upd(P2, 4'd0, 16'hBBBB);
        look(P2, 4'd0, '0, '0, 2'd0);
        expect_lk("R8 allocated entry hits", hit0, tgt0, 1'b1, 16'hBBBB);
        for (int i = 0; i < 24; i++) begin
            logic a, b;
            look(P, 4'd0, '0, '0, 2'd0);  a = hit0;
            look(P2, 4'd0, '0, '0, 2'd0); b = hit0;
            if (a && b) break;
            if (!a) upd(P, 4'd0, 16'hAAAA);
            else    upd(P2, 4'd0, 16'hBBBB);
        end
        look(P, 4'd0, '0, '0, 2'd0);
        expect_lk("R8 set fills both ways", hit0, tgt0, 1'b1, 16'hAAAA);
        for (int r = 0; r < 4; r++) begin
            upd(P, 4'd0, AW'(16'h3000 + r));
            look(P, 4'd0, '0, '0, 2'd0);
            expect_lk("R7 refresh target", hit0, tgt0, 1'b1, AW'(16'h3000 + r));
            look(P2, 4'd0, '0, '0, 2'd0);
            expect_lk("R7 other way kept", hit0, tgt0, 1'b1, 16'hBBBB);
        end

        // R8: replacement bounded by WAYS, other sets untouched
        do_reset();
        upd(16'h0014, 4'd0, 16'h7777); // aligned 5: set 5
        for (int t = 0; t < 16; t++) begin
            int hits;
            upd(AW'(t << 2), 4'((t & 7) ^ 1), AW'(16'h1000 + t));
            look(AW'(t << 2), 4'((t & 7) ^ 1), '0, '0, 2'd0);
            expect_lk("R8 new entry hits", hit0, tgt0, 1'b1, AW'(16'h1000 + t));
            hits = 0;
            for (int j = 0; j <= t; j++) begin
                look(AW'(j << 2), 4'((j & 7) ^ 1), '0, '0, 2'd0);
                if (hit0) begin
                    hits++;
                    if (tgt0 != AW'(16'h1000 + j))
                        chk(1'b0, "R8 resident target", {16'd0, tgt0}, 32'(16'h1000 + j));
                end
            end
            chk(hits <= 2, "R8 at most WAYS resident", hits, 2);
            if (t == 15) chk(hits == 2, "R8 set full after sweep", hits, 2);
        end
        look(16'h0014, 4'd0, '0, '0, 2'd0);
        expect_lk("R8 other set untouched", hit0, tgt0, 1'b1, 16'h7777);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule